// File: doc/BRIEF.md
# Switchable DC-Blocking High-Pass Filter

This block strips the DC offset from one stream of decimated PCM samples. It uses a first-order recursive high-pass section that runs at the output sample rate. Each accepted sample yields one filtered sample on the next clock. The feedback coefficient is `1 - 2^-K` and is built from a shift and a subtract, so the datapath has no multiplier. With the default `K = 12`, droop is about 0.03 dB at 0.00045·fs and rejection at 0.00000036·fs is about 40 dB. At DC the rejection is complete once the transient has decayed. Place one instance in each channel.

A single enable bit switches the section in or out while the stream is running. When the bit is clear, the sample is copied to the output with the same one-cycle latency, and the filter history is held at zero. A later enable therefore starts from a clean history. A small controller tracks three states:
- `ST_BYPASS`: the filter is off.
- `ST_PRIME`: the filter is enabled but no sample has arrived yet.
- `ST_RUN`: the filter is enabled and holds history.

The transitions are:
- ARM: `ST_BYPASS`→`ST_PRIME`, when the enable rises with no sample.
- ARM_AND_FIRE: `ST_BYPASS`→`ST_RUN`, when the enable and a sample arrive together.
- FIRST: `ST_PRIME`→`ST_RUN`, on the first sample.
- DROP: any state→`ST_BYPASS`, when the enable clears.

The feedback register keeps `F` extra fractional bits. The output is rounded and then saturated.

Top module: `dcb_hpf`

## Requirements
- R1: While `rst_n` is low, and after it rises, `out_valid` is 0 and `out_sample` is 0 until the first accepted sample.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. It is low after every cycle in which `in_valid` is low.
- R3: When `hpf_en` is 0 in a cycle with `in_valid` high, the next `out_sample` equals that `in_sample`, bit for bit.
- R4: When `hpf_en` is 1 in a cycle with `in_valid` high, the block computes a new accumulator value from the current sample x, the previous accepted sample xp and the held accumulator acc:
  - acc' = (x − xp)·2^F + acc − floor(acc / 2^K)
  - the output is floor((acc' + 2^(F−1)) / 2^F), clamped as in R5
  - acc' and x then become the new history.
  - All values are two's complement. F = 16 and K = 12 by default.
- R5: The filtered output is saturated to the signed range [−2^(W−1), 2^(W−1)−1]. With W = 16 this is −32768..32767.
- R6: Any cycle with `hpf_en` at 0 clears xp and acc to zero. The first filtered sample after re-enabling therefore equals its input.
- R7: A cycle with `in_valid` low changes neither the history nor `out_sample`. `out_sample` keeps its last value.
- R8: A constant input held for 60000 filtered samples produces outputs within ±1 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpf_en | input | 1 | 1 = filter active, 0 = pass-through with history cleared |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | W | Signed input PCM sample |
| out_valid | output | 1 | Qualifies `out_sample`, one cycle after `in_valid` |
| out_sample | output | W | Signed output sample (filtered or passed through) |

## Verification
The bound checker checks four rules on every cycle:
- the one-cycle valid latency;
- the exact pass-through in bypass;
- the hold of the output across idle cycles;
- the rule that the first sample after an enable equals its input, which ties the controller state to the ports.

The bit-exact recursion, saturation at the rails and settling to zero under a constant input need long sample histories. Only the bench's scenarios can show these. The bench compares every output against a bench-side model of the R4 arithmetic, under random and directed stimulus.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Controller modes of the DC-blocking section
    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_PRIME  = 2'd1,
        ST_RUN    = 2'd2
    } dcb_state_e;

endpackage

// File: rtl/dcb_ctrl.sv
module dcb_ctrl
    import dcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hpf_en,
    input  logic       in_valid,
    output dcb_state_e state_o,
    output logic       clr_hist,
    output logic       upd_hist
);

    dcb_state_e state_q;
    dcb_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: ARM, ARM_AND_FIRE, FIRST, DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: begin
                if (hpf_en) begin
                    state_d = in_valid ? ST_RUN : ST_PRIME;
                end
            end
            ST_PRIME: begin
                if (!hpf_en) begin
                    state_d = ST_BYPASS;
                end else if (in_valid) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!hpf_en) begin
                    state_d = ST_BYPASS;
                end
            end
            default: state_d = ST_BYPASS;
        endcase
    end

    // Outputs to the history registers
    always_comb begin
        clr_hist = !hpf_en;
        upd_hist = hpf_en && in_valid;
    end

    assign state_o = state_q;

endmodule

// File: rtl/dcb_arith.sv
module dcb_arith #(
    parameter int W  = 16,
    parameter int K  = 12,
    parameter int F  = 16,
    parameter int AW = W + F + 3,
    localparam int YW = AW - F
) (
    input  logic signed [W-1:0]  x_i,
    input  logic signed [W-1:0]  x_prev_i,
    input  logic signed [AW-1:0] acc_i,
    output logic signed [AW-1:0] acc_o,
    output logic signed [YW-1:0] y_o
);

    localparam logic signed [AW-1:0] HALF_LSB = {{(AW-1){1'b0}}, 1'b1} << (F - 1);

    logic signed [AW-1:0] x_ext;
    logic signed [AW-1:0] xp_ext;
    logic signed [AW-1:0] diff_scaled;
    logic signed [AW-1:0] leak;
    logic signed [AW-1:0] fb;
    logic signed [AW-1:0] rounded;

    always_comb begin
        x_ext       = {{(AW-W){x_i[W-1]}}, x_i};
        xp_ext      = {{(AW-W){x_prev_i[W-1]}}, x_prev_i};
        diff_scaled = (x_ext - xp_ext) <<< F;
        // a*acc with a = 1 - 2^-K, floor shift
        leak        = acc_i >>> K;
        fb          = acc_i - leak;
        acc_o       = diff_scaled + fb;
        rounded     = acc_o + HALF_LSB;
        y_o         = rounded[AW-1:F];
    end

endmodule

// File: rtl/dcb_sat.sv
module dcb_sat #(
    parameter int IW = 19,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] d_i,
    output logic signed [OW-1:0] q_o
);

    generate
        if (IW > OW) begin : g_clamp
            localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
            localparam logic signed [IW-1:0] LO = ~HI;
            always_comb begin
                if (d_i > HI) begin
                    q_o = HI[OW-1:0];
                end else if (d_i < LO) begin
                    q_o = LO[OW-1:0];
                end else begin
                    q_o = d_i[OW-1:0];
                end
            end
        end else begin : g_pass
            always_comb q_o = OW'(d_i);
        end
    endgenerate

endmodule

// File: rtl/dcb_hpf.sv
module dcb_hpf
    import dcb_pkg::*;
#(
    parameter int W = 16,
    parameter int K = 12,
    parameter int F = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hpf_en,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    output logic                out_valid,
    output logic signed [W-1:0] out_sample
);

    localparam int AW = W + F + 3;
    localparam int YW = AW - F;

    dcb_state_e           state_q;
    logic                 clr_hist;
    logic                 upd_hist;
    logic signed [W-1:0]  x_prev_q;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] acc_next;
    logic signed [YW-1:0] y_round;
    logic signed [W-1:0]  y_sat;

    dcb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hpf_en   (hpf_en),
        .in_valid (in_valid),
        .state_o  (state_q),
        .clr_hist (clr_hist),
        .upd_hist (upd_hist)
    );

    dcb_arith #(.W(W), .K(K), .F(F), .AW(AW)) u_arith (
        .x_i      (in_sample),
        .x_prev_i (x_prev_q),
        .acc_i    (acc_q),
        .acc_o    (acc_next),
        .y_o      (y_round)
    );

    dcb_sat #(.IW(YW), .OW(W)) u_sat (
        .d_i (y_round),
        .q_o (y_sat)
    );

    // Filter history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_prev_q <= '0;
            acc_q    <= '0;
        end else if (clr_hist) begin
            x_prev_q <= '0;
            acc_q    <= '0;
        end else if (upd_hist) begin
            x_prev_q <= in_sample;
            acc_q    <= acc_next;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= hpf_en ? y_sat : in_sample;
            end
        end
    end

endmodule

// File: rtl/dcb_hpf_chk.sv
module dcb_hpf_chk
    import dcb_pkg::*;
#(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hpf_en,
    input logic                in_valid,
    input logic signed [W-1:0] in_sample,
    input logic                out_valid,
    input logic signed [W-1:0] out_sample,
    input dcb_state_e          state_q
);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_bypass_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hpf_en) |=> (out_sample == $past(in_sample)));

    p_fresh_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hpf_en && state_q != ST_RUN) |=> (out_sample == $past(in_sample)));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

endmodule

bind dcb_hpf dcb_hpf_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hpf_en     (hpf_en),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .state_q    (state_q)
);

// File: tb/dcb_hpf_tb.sv
module dcb_hpf_tb_top;

    localparam int W = 16;
    localparam int K = 12;
    localparam int F = 16;
    localparam time CLK_PERIOD = 10ns;
    localparam longint HI = (64'sd1 <<< (W - 1)) - 1;
    localparam longint LO = -(64'sd1 <<< (W - 1));

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                hpf_en = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic                out_valid;
    logic signed [W-1:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    longint m_xp = 0;
    longint m_acc = 0;
    bit     exp_valid = 1'b0;
    longint exp_sample = 0;
    string  exp_tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    dcb_hpf #(.W(W), .K(K), .F(F)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hpf_en     (hpf_en),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic longint clamp(input longint v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Compare previous cycle's expectation, then drive the next cycle
    task automatic cyc(input bit en, input bit v, input longint x, input string tag);
        longint acc_n;
        longint y;
        @(negedge clk);
        check({exp_tag, " valid (R2)"}, longint'(out_valid), longint'(exp_valid));
        check({exp_tag, " sample"}, longint'(out_sample), exp_sample);
        hpf_en    = en;
        in_valid  = v;
        in_sample = x[W-1:0];
        if (!en) begin
            m_xp  = 0;
            m_acc = 0;
            if (v) exp_sample = x;
        end else if (v) begin
            acc_n      = (x - m_xp) * (64'sd1 <<< F) + m_acc - (m_acc >>> K);
            y          = (acc_n + (64'sd1 <<< (F - 1))) >>> F;
            exp_sample = clamp(y);
            m_xp       = x;
            m_acc      = acc_n;
        end
        exp_valid = v;
        exp_tag   = tag;
    endtask

    function automatic longint rnd_sample();
        logic [31:0] r;
        r = $urandom;
        return longint'($signed(r[W-1:0]));
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 reset valid", longint'(out_valid), 0);
        check("R1 reset sample", longint'(out_sample), 0);
        rst_n = 1'b1;

        // R3: bypass with random data and gaps (R7)
        for (int i = 0; i < 300; i++) begin
            r = $urandom;
            cyc(1'b0, r[1:0] != 2'b00, rnd_sample(), "R3");
        end

        // R4 / R7: filtered random data with random gaps
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            cyc(1'b1, r[1:0] != 2'b00, rnd_sample() >>> (r[4:2]), "R4");
        end

        // R6: drop then re-enable, first sample equals input
        cyc(1'b0, 1'b0, 0, "R6");
        cyc(1'b1, 1'b1, 12345, "R6");
        cyc(1'b1, 1'b0, 0, "R7");
        check("R6 first after enable", longint'(out_sample), 12345);
        cyc(1'b1, 1'b0, 0, "R7");
        check("R7 hold across idle", longint'(out_sample), 12345);

        // R5: rail-to-rail alternation forces saturation
        cyc(1'b0, 1'b0, 0, "R5");
        cyc(1'b1, 1'b1, HI, "R5");
        cyc(1'b1, 1'b1, LO, "R5");
        cyc(1'b1, 1'b0, 0, "R5");
        check("R5 negative rail", longint'(out_sample), LO);
        cyc(1'b1, 1'b1, HI, "R5");
        cyc(1'b1, 1'b0, 0, "R5");
        check("R5 positive rail", longint'(out_sample), HI);

        // R8: long constant input settles to zero
        cyc(1'b0, 1'b0, 0, "R8");
        for (int i = 0; i < 60000; i++) begin
            cyc(1'b1, 1'b1, 20000, "R8");
        end
        cyc(1'b1, 1'b0, 0, "R8");
        checks++;
        if (out_sample > 1 || out_sample < -1) begin
            errors++;
            $display("FAIL R8 actual %0d expected within +-1 of 0", out_sample);
        end

        // R3: bypass again after filtering, negative extremes
        cyc(1'b0, 1'b1, LO, "R3");
        cyc(1'b0, 1'b1, -1, "R3");
        cyc(1'b0, 1'b0, 0, "R3");
        check("R3 bypass last", longint'(out_sample), -1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule